// File: doc/BRIEF.md
# Rotate-Extend and Byte-Reverse Unit

This block is a datapath stage for sub-word handling of a 32-bit value. In its extend mode it first rotates the source right by 0, 8, 16 or 24 bits. It then takes the low byte or the low halfword of the rotated word and widens it to 32 bits, with a sign fill or a zero fill. It can add a second operand to that widened value. In its reverse modes it reorders the bytes of the source in one of three ways: the whole word, each 16-bit half on its own, or the low halfword followed by a sign extension.

The operation code, the rotate field, the signed and size selects and the accumulate register number are presented together with the two operands. An accumulate register number of 15 means "no accumulate". The result is registered and appears one clock after the inputs are sampled. An operation code that is not supported gives a zero result and raises an illegal flag in the same cycle.

Top module: `rot_ext_rev`

## Requirements
- R1: While `rst_n` is low, `res` is 0 and `bad_op` is 0.
- R2: In extend mode (`op_sel` = 3), the source is rotated right by `rot_sel`×8 bits before the field is taken.
- R3: A byte extend (`half_sel` = 0) uses bits 7:0 of the rotated value. If `sgn` = 1 and bit 7 is set, bits 31:8 are all ones; otherwise they are zero.
- R4: A halfword extend (`half_sel` = 1) uses bits 15:0 of the rotated value. If `sgn` = 1 and bit 15 is set, bits 31:16 are all ones; otherwise they are zero.
- R5: When `acc_reg` = 15, the result of an extend is the extended value alone. For any other `acc_reg`, the result is `acc_val` plus the extended value, modulo 2^32, and no carry is reported.
- R6: `op_sel` = 1 reverses all four bytes: result byte k equals source byte 3−k. `sgn`, `half_sel`, `rot_sel` and the accumulate inputs have no effect on it.
- R7: `op_sel` = 5 with `sgn` = 0 swaps the two bytes inside each 16-bit half independently: result byte k equals source byte k XOR 1.
- R8: `op_sel` = 5 with `sgn` = 1 places source byte 0 in result bits 15:8 and source byte 1 in bits 7:0, then copies the new bit 15 into bits 31:16.
- R9: Every `op_sel` value other than 1, 3 or 5 gives `res` = 0 and `bad_op` = 1. The supported values give `bad_op` = 0.
- R10: The inputs sampled at a rising clock edge determine `res` and `bad_op` after that edge. The outputs hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_val | input | 32 | Source operand |
| acc_val | input | 32 | Accumulate operand |
| acc_reg | input | 4 | Accumulate register number; 15 suppresses the add |
| rot_sel | input | 2 | Right-rotate amount in bytes (extend mode) |
| sgn | input | 1 | 1 = signed fill / signed halfword reverse |
| half_sel | input | 1 | 1 = halfword extend, 0 = byte extend |
| op_sel | input | 3 | 1 = full reverse, 3 = extend, 5 = halfword reverse, others illegal |
| res | output | 32 | Registered result |
| bad_op | output | 1 | Registered illegal-operation flag |

## Verification
The assertions assume that every input is at a known value at each rising edge. They also assume that `rst_n` is held low for at least one edge before checks start, because each property compares the outputs with the inputs of the previous cycle through `$past`. The stimulus drives all inputs only on falling edges and applies them as whole vectors, so the sampled values never mix two vectors. Random vectors draw `op_sel` from all eight codes and `acc_reg` from all sixteen numbers, so the illegal-code path and the no-accumulate path both occur alongside the supported operations.

// File: rtl/rot_ext_rev.sv
module rot_ext_rev #(
  parameter logic [3:0] NO_ACC = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_val,
  input  logic [31:0] acc_val,
  input  logic [3:0]  acc_reg,
  input  logic [1:0]  rot_sel,
  input  logic        sgn,
  input  logic        half_sel,
  input  logic [2:0]  op_sel,
  output logic [31:0] res,
  output logic        bad_op
);
  localparam logic [2:0] OP_REV  = 3'd1;
  localparam logic [2:0] OP_EXT  = 3'd3;
  localparam logic [2:0] OP_HREV = 3'd5;

  logic [4:0]  shamt;
  logic [31:0] rot_v, ext_v, sum_v, hrev_v, nxt;
  logic        nxt_bad;

  assign shamt  = {rot_sel, 3'b000};
  assign rot_v  = (src_val >> shamt) | (src_val << (6'd32 - {1'b0, shamt}));
  assign ext_v  = half_sel ? {{16{sgn & rot_v[15]}}, rot_v[15:0]}
                           : {{24{sgn & rot_v[7]}},  rot_v[7:0]};
  assign sum_v  = (acc_reg == NO_ACC) ? ext_v : acc_val + ext_v;
  assign hrev_v = sgn ? {{16{src_val[7]}}, src_val[7:0], src_val[15:8]}
                      : {src_val[23:16], src_val[31:24], src_val[7:0], src_val[15:8]};

  always_comb begin
    nxt     = '0;
    nxt_bad = 1'b0;
    case (op_sel)
      OP_REV:  nxt = {src_val[7:0], src_val[15:8], src_val[23:16], src_val[31:24]};
      OP_EXT:  nxt = sum_v;
      OP_HREV: nxt = hrev_v;
      default: nxt_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= '0;
      bad_op <= 1'b0;
    end else begin
      res    <= nxt;
      bad_op <= nxt_bad;
    end
  end
endmodule

module rot_ext_rev_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] src_val,
  input logic [31:0] acc_val,
  input logic [3:0]  acc_reg,
  input logic [1:0]  rot_sel,
  input logic        sgn,
  input logic        half_sel,
  input logic [2:0]  op_sel,
  input logic [31:0] res,
  input logic        bad_op
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (res == 32'd0 && !bad_op));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> res == 32'd0);

  assert_legal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1 || op_sel == 3'd3 || op_sel == 3'd5) |=> !bad_op);

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_sel == 3'd1 || op_sel == 3'd3 || op_sel == 3'd5) |=> bad_op);

  assert_full_rev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 3'd1 |=> (res[31:24] == $past(src_val[7:0]) &&
                        res[7:0]   == $past(src_val[31:24])));

  assert_signed_hrev_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd5 && sgn) |=> (res[31:16] == {16{res[15]}} &&
                                 res[15:8] == $past(src_val[7:0])));

  assert_ubyte_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 && !sgn && !half_sel && acc_reg == 4'hF) |=> res[31:8] == 24'd0);

  assert_uhalf_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 && !sgn && half_sel && acc_reg == 4'hF) |=> res[31:16] == 16'd0);
endmodule

bind rot_ext_rev rot_ext_rev_chk u_chk (.*);

// File: tb/sim_rot_ext_rev.sv
`timescale 1ns/1ps
module sim_rot_ext_rev;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_val = '0, acc_val = '0;
  logic [3:0]  acc_reg = 4'hF;
  logic [1:0]  rot_sel = '0;
  logic        sgn = 1'b0, half_sel = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] res;
  logic        bad_op;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rot_ext_rev u0 (.*);

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  function automatic void model(input logic [31:0] s, input logic [31:0] a, input logic [3:0] ar,
                                input logic [1:0] rs, input logic sg, input logic hs, input logic [2:0] op,
                                output logic [31:0] e, output logic eb);
    logic [31:0] r;
    longint unsigned v;
    e = '0; eb = 1'b0;
    if (op == 3'd1) begin
      for (int k = 0; k < 4; k++) e[8*k +: 8] = byte_of(s, 3 - k);
    end else if (op == 3'd5) begin
      if (!sg) begin
        for (int k = 0; k < 4; k++) e[8*k +: 8] = byte_of(s, k ^ 1);
      end else begin
        e[15:8] = byte_of(s, 0);
        e[7:0]  = byte_of(s, 1);
        if (e[15]) e[31:16] = 16'hFFFF;
      end
    end else if (op == 3'd3) begin
      for (int i = 0; i < 32; i++) r[i] = s[(i + 8*int'(rs)) % 32];
      if (hs) begin
        v = r[15:0];
        if (sg && r[15]) v = v + 64'hFFFF_0000;
      end else begin
        v = r[7:0];
        if (sg && r[7]) v = v + 64'hFFFF_FF00;
      end
      if (ar != 4'd15) v = v + a;
      e = v[31:0];
    end else begin
      eb = 1'b1;
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic eb);
    n_chk++;
    if (res !== er || bad_op !== eb) begin
      n_bad++;
      $display("FAIL %s: res=%h bad_op=%b expected res=%h bad_op=%b", tag, res, bad_op, er, eb);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] s, input logic [31:0] a, input logic [3:0] ar,
                     input logic [1:0] rs, input logic sg, input logic hs, input logic [2:0] op);
    logic [31:0] e;
    logic eb;
    src_val = s; acc_val = a; acc_reg = ar; rot_sel = rs; sgn = sg; half_sel = hs; op_sel = op;
    model(s, a, ar, rs, sg, hs, op, e, eb);
    @(negedge clk);
    check(tag, e, eb);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: res=%h expected completion", res);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    op_sel = 3'd1; src_val = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R1", 32'd0, 1'b0);
    rst_n = 1'b1;
    // R2 rotations, R3 byte extend
    run("R2", 32'h11223344, 0, 4'hF, 2'd0, 0, 0, 3'd3);
    run("R2", 32'h11223344, 0, 4'hF, 2'd1, 0, 0, 3'd3);
    run("R2", 32'h11223344, 0, 4'hF, 2'd2, 0, 0, 3'd3);
    run("R2", 32'h11223344, 0, 4'hF, 2'd3, 0, 1, 3'd3);
    run("R3", 32'h00000080, 0, 4'hF, 2'd0, 1, 0, 3'd3);
    run("R3", 32'h00000080, 0, 4'hF, 2'd0, 0, 0, 3'd3);
    run("R3", 32'h7F000000, 0, 4'hF, 2'd3, 1, 0, 3'd3);
    // R4 halfword extend
    run("R4", 32'h00008001, 0, 4'hF, 2'd0, 1, 1, 3'd3);
    run("R4", 32'h00008001, 0, 4'hF, 2'd0, 0, 1, 3'd3);
    run("R4", 32'h80010000, 0, 4'hF, 2'd2, 1, 1, 3'd3);
    run("R4", 32'h00FF8000, 0, 4'hF, 2'd1, 1, 1, 3'd3);
    // R5 accumulate
    run("R5", 32'h000000FF, 32'h00000001, 4'h3, 2'd0, 1, 0, 3'd3);
    run("R5", 32'h0000FFFF, 32'hFFFF0001, 4'h0, 2'd0, 0, 1, 3'd3);
    run("R5", 32'h00000010, 32'h12345678, 4'hE, 2'd0, 0, 0, 3'd3);
    run("R5", 32'h00000010, 32'h12345678, 4'hF, 2'd0, 0, 0, 3'd3);
    // R6 full reverse, other inputs ignored
    run("R6", 32'h12345678, 32'hFFFFFFFF, 4'h1, 2'd3, 1, 1, 3'd1);
    run("R6", 32'hA1B2C3D4, 0, 4'hF, 2'd0, 0, 0, 3'd1);
    // R7 / R8 halfword reverses
    run("R7", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd5);
    run("R7", 32'hFF00AA55, 32'h1, 4'h2, 2'd2, 0, 1, 3'd5);
    run("R8", 32'h12345680, 0, 4'hF, 2'd0, 1, 0, 3'd5);
    run("R8", 32'hFFFF7F01, 0, 4'hF, 2'd1, 1, 1, 3'd5);
    // R9 illegal codes
    run("R9", 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0, 2'd1, 1, 1, 3'd0);
    run("R9", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd2);
    run("R9", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd4);
    run("R9", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd6);
    run("R9", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd7);
    run("R9", 32'h12345678, 0, 4'hF, 2'd0, 0, 0, 3'd1);
    // R10 hold: inputs change between edges are not seen until the edge
    run("R10", 32'hCAFEF00D, 0, 4'hF, 2'd0, 0, 0, 3'd1);
    #1 src_val = 32'h0;
    #0.5 check("R10", 32'h0DF0FECA, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      run("R10", $urandom, $urandom, 4'($urandom), 2'($urandom), 1'($urandom),
          1'($urandom), 3'($urandom));
    end
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 32'd0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule